// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block maps a virtual address to a real address through a fully associative table of 64 translation entries. Each entry describes one page. The page can be 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB or 16 MB, and each entry picks its own size. The size decides how many upper address bits take part in the match and how many are replaced by the entry's real page number. An entry can belong to one process, through an 8-bit tag, or it can be shared by all processes when the tag is zero.

Software programs the table one word at a time. A word select chooses between the 36-bit match word and the 32-bit translation word of an entry, and an index chooses the entry. The same index and select read a word back one cycle later. The lookup port is combinational. It takes an address, a fetch/data flag, a translation-enable bit and the current process ID. It returns the real address, a hit flag, the index of the winning entry, that entry's permission and attribute bits, and a miss indication for either instruction fetches or data accesses. When translation is off, the address passes through unchanged.

Top module: `vps_tlb`

## Requirements
- R1: A synchronous active-high reset clears every entry to all zeros, so no entry is valid, and it sets the readback register to zero.
- R2: A write with the word select high stores the 36-bit match word. A write with the select low stores the low 32 bits of the write data as the translation word. The readback port returns the selected word of the indexed entry one cycle after the index is presented, with the translation word zero-extended to 36 bits.
- R3: Match word layout, from the least significant bit: process tag [7:0], user-defined-0 [8], little-endian [9], valid [10], size code [13:11], page number [35:14]. The page number stands for virtual address bits [31:10].
- R4: Translation word layout, from the least significant bit: guarded [0], coherent [1], cache-inhibit [2], write-through [3], zone [7:4], write-enable [8], execute-enable [9], real page number [31:10]. On a hit the outputs carry these bits and the endian and user-defined-0 bits of the winning entry. On any other lookup they are zero.
- R5: A size code n compares virtual address bits [31:10+2n] with the matching page-number bits. Lower page-number bits are ignored.
- R6: On a hit the real address takes bits [31:10+2n] from the real page number and the lower bits from the virtual address. Real page-number bits below that boundary are ignored.
- R7: An entry whose valid bit is clear never matches.
- R8: An entry with a nonzero process tag matches only when the tag equals the lookup process ID. A zero tag matches any ID.
- R9: When several entries match, the one with the lowest index wins, and its index appears on the index output.
- R10: With translation enabled and no matching entry, the block raises the instruction miss for a fetch or the data miss for a load or store, never both. It also drives the hit flag, the index and the real address to zero.
- R11: With translation disabled, the real address equals the virtual address. Hit, both misses and all attribute outputs are zero, whatever the table holds.
- R12: A write changes the lookup result from the clock edge that performs it onward. A lookup in the cycle before that edge still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Write strobe for the table |
| sw_hi | input | 1 | Word select: 1 = match word, 0 = translation word |
| sw_idx | input | 6 | Entry index for write and readback |
| sw_wdata | input | 36 | Write data (translation word uses [31:0]) |
| sw_rdata | output | 36 | Registered readback of the selected word |
| lk_va | input | 32 | Virtual address to translate |
| lk_fetch | input | 1 | 1 = instruction fetch, 0 = load/store |
| lk_xlat_en | input | 1 | Translation enable for this access |
| lk_pid | input | 8 | Current process ID |
| lk_ra | output | 32 | Real address |
| lk_hit | output | 1 | An entry matched |
| lk_idx | output | 6 | Index of the winning entry |
| lk_ex | output | 1 | Execute-enable of the winning entry |
| lk_wr | output | 1 | Write-enable of the winning entry |
| lk_zone | output | 4 | Zone select of the winning entry |
| lk_wimg | output | 4 | Write-through, inhibit, coherent, guarded bits (MSB first) |
| lk_endian | output | 1 | Little-endian bit of the winning entry |
| lk_u0 | output | 1 | User-defined-0 bit of the winning entry |
| lk_miss_i | output | 1 | Instruction miss |
| lk_miss_d | output | 1 | Data miss |

## Verification
The assertions check on every cycle that disabled translation passes the address through with no hit and no miss, that a miss has the kind the fetch flag calls for and never both kinds at once, that a hit keeps the low ten address bits, and that no entry hits right after reset. The bench scenarios are needed for the rest: that page sizes bound the compare and replace correctly, that process tags filter entries, that the lowest index wins among overlapping pages, that the attribute fields come from the right bit positions, and that a write takes effect exactly at its clock edge.

// File: rtl/vps_tlb_pkg.sv
package vps_tlb_pkg;
  localparam int VA_W    = 32;
  localparam int PID_W   = 8;
  localparam int PN_W    = 22;
  localparam int SZ_W    = 3;
  localparam int ZONE_W  = 4;
  localparam int PG_MIN  = VA_W - PN_W;   // smallest page offset width
  localparam int PG_STEP = 2;             // offset grows by this per size code

  localparam int HI_W = PN_W + SZ_W + 3 + PID_W;
  localparam int LO_W = PN_W + 2 + ZONE_W + 4;

  // match word positions
  localparam int HI_TAG_LSB = 0;
  localparam int HI_U0      = PID_W;
  localparam int HI_LE      = PID_W + 1;
  localparam int HI_VLD     = PID_W + 2;
  localparam int HI_SZ_LSB  = PID_W + 3;
  localparam int HI_PN_LSB  = HI_SZ_LSB + SZ_W;

  // translation word positions
  localparam int LO_ATT_LSB  = 0;
  localparam int LO_ZONE_LSB = 4;
  localparam int LO_WE       = LO_ZONE_LSB + ZONE_W;
  localparam int LO_XE       = LO_WE + 1;
  localparam int LO_PN_LSB   = LO_XE + 1;

  typedef struct packed {
    logic              ex;
    logic              wr;
    logic [ZONE_W-1:0] zone;
    logic [3:0]        wimg;
    logic              endian;
    logic              u0;
  } tlb_attr_t;

  // ones on the address bits that belong to the page number for a size code
  function automatic logic [VA_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
    return {VA_W{1'b1}} << (PG_MIN + PG_STEP * int'(sz));
  endfunction
endpackage

// File: rtl/vps_tlb_store.sv
module vps_tlb_store
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic                          hi_sel,
  input  logic [IDX_W-1:0]              idx,
  input  logic [HI_W-1:0]               wdata,
  output logic [HI_W-1:0]               rdata,
  output logic [ENTRIES-1:0][HI_W-1:0]  hi_q,
  output logic [ENTRIES-1:0][LO_W-1:0]  lo_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      rdata <= '0;
    end else begin
      if (wr) begin
        if (hi_sel) hi_q[idx] <= wdata;
        else        lo_q[idx] <= wdata[LO_W-1:0];
      end
      rdata <= hi_sel ? hi_q[idx] : {{(HI_W-LO_W){1'b0}}, lo_q[idx]};
    end
  end
endmodule

// File: rtl/vps_tlb_match.sv
module vps_tlb_match
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic [ENTRIES-1:0][HI_W-1:0] hi_q,
  input  logic [VA_W-1:0]              va,
  input  logic [PID_W-1:0]             pid,
  output logic [ENTRIES-1:0]           hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [PN_W-1:0]  pn;
    logic [SZ_W-1:0]  sz;
    logic [PID_W-1:0] tag;
    logic             vld;
    logic             addr_eq;
    logic             tag_ok;

    assign pn  = hi_q[g][HI_PN_LSB +: PN_W];
    assign sz  = hi_q[g][HI_SZ_LSB +: SZ_W];
    assign tag = hi_q[g][HI_TAG_LSB +: PID_W];
    assign vld = hi_q[g][HI_VLD];

    assign addr_eq = ((va ^ {pn, {PG_MIN{1'b0}}}) & page_mask(sz)) == '0;
    assign tag_ok  = (tag == '0) || (tag == pid);
    assign hit_vec[g] = vld && addr_eq && tag_ok;
  end
endmodule

// File: rtl/vps_tlb_select.sv
module vps_tlb_select
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][HI_W-1:0] hi_q,
  input  logic [ENTRIES-1:0][LO_W-1:0] lo_q,
  input  logic [ENTRIES-1:0]           hit_vec,
  input  logic [VA_W-1:0]              va,
  output logic                         found,
  output logic [IDX_W-1:0]             win_idx,
  output logic [VA_W-1:0]              xlat_ra,
  output tlb_attr_t                    attr
);
  logic [HI_W-1:0] hi_w;
  logic [LO_W-1:0] lo_w;
  logic [VA_W-1:0] keep;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i] && !found) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

  assign hi_w = hi_q[win_idx];
  assign lo_w = lo_q[win_idx];
  assign keep = page_mask(hi_w[HI_SZ_LSB +: SZ_W]);

  always_comb begin
    xlat_ra = '0;
    attr    = '0;
    if (found) begin
      xlat_ra     = ({lo_w[LO_PN_LSB +: PN_W], {PG_MIN{1'b0}}} & keep) | (va & ~keep);
      attr.ex     = lo_w[LO_XE];
      attr.wr     = lo_w[LO_WE];
      attr.zone   = lo_w[LO_ZONE_LSB +: ZONE_W];
      attr.wimg   = lo_w[LO_ATT_LSB +: 4];
      attr.endian = hi_w[HI_LE];
      attr.u0     = hi_w[HI_U0];
    end
  end
endmodule

// File: rtl/vps_tlb.sv
module vps_tlb
  import vps_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_wr,
  input  logic              sw_hi,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [HI_W-1:0]   sw_wdata,
  output logic [HI_W-1:0]   sw_rdata,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              lk_fetch,
  input  logic              lk_xlat_en,
  input  logic [PID_W-1:0]  lk_pid,
  output logic [VA_W-1:0]   lk_ra,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic              lk_ex,
  output logic              lk_wr,
  output logic [ZONE_W-1:0] lk_zone,
  output logic [3:0]        lk_wimg,
  output logic              lk_endian,
  output logic              lk_u0,
  output logic              lk_miss_i,
  output logic              lk_miss_d
);
  logic [ENTRIES-1:0][HI_W-1:0] hi_q;
  logic [ENTRIES-1:0][LO_W-1:0] lo_q;
  logic [ENTRIES-1:0]           hit_vec;
  logic                         found;
  logic [IDX_W-1:0]             win_idx;
  logic [VA_W-1:0]              xlat_ra;
  tlb_attr_t                    attr;
  tlb_attr_t                    attr_o;

  vps_tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .wr(sw_wr), .hi_sel(sw_hi), .idx(sw_idx),
    .wdata(sw_wdata), .rdata(sw_rdata), .hi_q(hi_q), .lo_q(lo_q)
  );

  vps_tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .hi_q(hi_q), .va(lk_va), .pid(lk_pid), .hit_vec(hit_vec)
  );

  vps_tlb_select #(.ENTRIES(ENTRIES)) u_sel (
    .hi_q(hi_q), .lo_q(lo_q), .hit_vec(hit_vec), .va(lk_va),
    .found(found), .win_idx(win_idx), .xlat_ra(xlat_ra), .attr(attr)
  );

  assign lk_ra     = lk_xlat_en ? xlat_ra : lk_va;
  assign lk_hit    = lk_xlat_en && found;
  assign lk_idx    = lk_hit ? win_idx : '0;
  assign attr_o    = lk_hit ? attr : '0;
  assign lk_ex     = attr_o.ex;
  assign lk_wr     = attr_o.wr;
  assign lk_zone   = attr_o.zone;
  assign lk_wimg   = attr_o.wimg;
  assign lk_endian = attr_o.endian;
  assign lk_u0     = attr_o.u0;
  assign lk_miss_i = lk_xlat_en && !found && lk_fetch;
  assign lk_miss_d = lk_xlat_en && !found && !lk_fetch;
endmodule

// File: rtl/vps_tlb_chk.sv
module vps_tlb_chk
  import vps_tlb_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [VA_W-1:0]  lk_va,
  input logic             lk_fetch,
  input logic             lk_xlat_en,
  input logic [VA_W-1:0]  lk_ra,
  input logic             lk_hit,
  input logic             lk_miss_i,
  input logic             lk_miss_d
);
  assert_bypass_R11: assert property (@(posedge clk) disable iff (rst)
    !lk_xlat_en |-> (lk_ra == lk_va) && !lk_hit && !lk_miss_i && !lk_miss_d);

  assert_miss_kind_R10: assert property (@(posedge clk) disable iff (rst)
    (lk_xlat_en && !lk_hit) |-> (lk_miss_i == lk_fetch) && (lk_miss_d == !lk_fetch));

  assert_miss_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(lk_miss_i && lk_miss_d) && !(lk_hit && (lk_miss_i || lk_miss_d)));

  assert_offset_kept_R6: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_ra[PG_MIN-1:0] == lk_va[PG_MIN-1:0]));

  assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);
endmodule

bind vps_tlb vps_tlb_chk u_chk (
  .clk(clk), .rst(rst), .lk_va(lk_va), .lk_fetch(lk_fetch),
  .lk_xlat_en(lk_xlat_en), .lk_ra(lk_ra), .lk_hit(lk_hit),
  .lk_miss_i(lk_miss_i), .lk_miss_d(lk_miss_d)
);

// File: tb/test_vps_tlb.sv
module test_vps_tlb;
  logic        clk = 1'b0;
  logic        rst;
  logic        sw_wr, sw_hi;
  logic [5:0]  sw_idx;
  logic [35:0] sw_wdata, sw_rdata;
  logic [31:0] lk_va, lk_ra;
  logic        lk_fetch, lk_xlat_en, lk_hit, lk_ex, lk_wr, lk_endian, lk_u0;
  logic        lk_miss_i, lk_miss_d;
  logic [7:0]  lk_pid;
  logic [5:0]  lk_idx;
  logic [3:0]  lk_zone, lk_wimg;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vps_tlb i_vps_tlb (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_hi(sw_hi), .sw_idx(sw_idx),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .lk_va(lk_va), .lk_fetch(lk_fetch),
    .lk_xlat_en(lk_xlat_en), .lk_pid(lk_pid), .lk_ra(lk_ra), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_ex(lk_ex), .lk_wr(lk_wr), .lk_zone(lk_zone),
    .lk_wimg(lk_wimg), .lk_endian(lk_endian), .lk_u0(lk_u0),
    .lk_miss_i(lk_miss_i), .lk_miss_d(lk_miss_d)
  );

  // R3 layout: tag[7:0] u0[8] le[9] valid[10] size[13:11] page[35:14]
  function automatic logic [35:0] mk_hi(logic [21:0] pn, logic [2:0] sz, logic v,
                                        logic le, logic u0, logic [7:0] tag);
    return {pn, sz, v, le, u0, tag};
  endfunction
  // R4 layout: wimg[3:0] zone[7:4] we[8] xe[9] rpn[31:10]
  function automatic logic [35:0] mk_lo(logic [21:0] rpn, logic xe, logic we,
                                        logic [3:0] zone, logic [3:0] wimg);
    return {4'b0, rpn, xe, we, zone, wimg};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_word(logic [5:0] idx, logic hi, logic [35:0] d);
    @(negedge clk);
    sw_wr = 1'b1; sw_hi = hi; sw_idx = idx; sw_wdata = d;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic look(logic [31:0] va, logic f, logic en, logic [7:0] pid);
    lk_va = va; lk_fetch = f; lk_xlat_en = en; lk_pid = pid;
    #1;
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        fetch;
    logic        en;
    logic [7:0]  pid;
    logic        hit;
    logic [5:0]  idx;
    logic [31:0] ra;
    logic        mi;
    logic        md;
    logic [11:0] attr;   // {ex, wr, zone, wimg, endian, u0}
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h1000_0000, 1'b0, 1'b1, 8'd0,  1'b0, 6'd0,  32'h0000_0000, 1'b0, 1'b1, 12'h000}, // R7
    '{32'h2012_3456, 1'b1, 1'b1, 8'h33, 1'b1, 6'd3,  32'h8012_3456, 1'b0, 1'b0, 12'hCC8}, // R5 R6 R8
    '{32'h3000_0123, 1'b0, 1'b1, 8'd5,  1'b1, 6'd5,  32'h4000_0523, 1'b0, 1'b0, 12'h000}, // R8
    '{32'h3000_0123, 1'b1, 1'b1, 8'd6,  1'b0, 6'd0,  32'h0000_0000, 1'b1, 1'b0, 12'h000}, // R8 R10
    '{32'h3000_0400, 1'b0, 1'b1, 8'd5,  1'b0, 6'd0,  32'h0000_0000, 1'b0, 1'b1, 12'h000}, // R5
    '{32'h5000_0ABC, 1'b0, 1'b1, 8'd0,  1'b1, 6'd7,  32'h6000_0ABC, 1'b0, 1'b0, 12'h000}, // R9
    '{32'h5000_1ABC, 1'b0, 1'b1, 8'd0,  1'b1, 6'd9,  32'h7000_1ABC, 1'b0, 1'b0, 12'h000}, // R5
    '{32'h900F_FFFF, 1'b1, 1'b1, 8'd9,  1'b1, 6'd10, 32'hA00F_FFFF, 1'b0, 1'b0, 12'hA97}, // R4 R6
    '{32'h2012_3456, 1'b1, 1'b0, 8'd0,  1'b0, 6'd0,  32'h2012_3456, 1'b0, 1'b0, 12'h000}, // R11
    '{32'hDEAD_BEEF, 1'b0, 1'b0, 8'd0,  1'b0, 6'd0,  32'hDEAD_BEEF, 1'b0, 1'b0, 12'h000}, // R11
    '{32'hDEAD_BEEF, 1'b1, 1'b1, 8'd0,  1'b0, 6'd0,  32'h0000_0000, 1'b1, 1'b0, 12'h000}  // R10
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; sw_wr = 1'b0; sw_hi = 1'b0; sw_idx = '0; sw_wdata = '0;
    lk_va = '0; lk_fetch = 1'b0; lk_xlat_en = 1'b0; lk_pid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: cleared table and readback
    check("R1", "rdata after reset", 64'(sw_rdata), 64'h0);
    look(32'h0000_0000, 1'b0, 1'b1, 8'd0);
    check("R1", "hit after reset", 64'(lk_hit), 64'h0);
    check("R1", "data miss after reset", 64'(lk_miss_d), 64'h1);

    // program the table
    wr_word(6'd0,  1'b1, mk_hi(22'h040000, 3'd0, 1'b0, 1'b0, 1'b0, 8'd0));
    wr_word(6'd0,  1'b0, mk_lo(22'h000123, 1'b1, 1'b1, 4'h1, 4'h1));
    wr_word(6'd3,  1'b1, mk_hi(22'h080000, 3'd7, 1'b1, 1'b0, 1'b0, 8'd0));
    wr_word(6'd3,  1'b0, mk_lo(22'h200000, 1'b1, 1'b1, 4'h3, 4'h2));
    wr_word(6'd5,  1'b1, mk_hi(22'h0C0000, 3'd0, 1'b1, 1'b0, 1'b0, 8'd5));
    wr_word(6'd5,  1'b0, mk_lo(22'h100001, 1'b0, 1'b0, 4'h0, 4'h0));
    wr_word(6'd7,  1'b1, mk_hi(22'h140000, 3'd1, 1'b1, 1'b0, 1'b0, 8'd0));
    wr_word(6'd7,  1'b0, mk_lo(22'h180000, 1'b0, 1'b0, 4'h0, 4'h0));
    wr_word(6'd9,  1'b1, mk_hi(22'h140000, 3'd3, 1'b1, 1'b0, 1'b0, 8'd0));
    wr_word(6'd9,  1'b0, mk_lo(22'h1C0000, 1'b0, 1'b0, 4'h0, 4'h0));
    wr_word(6'd10, 1'b1, mk_hi(22'h2403FF, 3'd5, 1'b1, 1'b1, 1'b1, 8'd9));
    wr_word(6'd10, 1'b0, mk_lo(22'h2803FF, 1'b1, 1'b0, 4'hA, 4'h5));

    // table walk
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      look(VECS[k].va, VECS[k].fetch, VECS[k].en, VECS[k].pid);
      check("R5-table", $sformatf("vec %0d hit", k), 64'(lk_hit), 64'(VECS[k].hit));
      check("R9-table", $sformatf("vec %0d idx", k), 64'(lk_idx), 64'(VECS[k].idx));
      check("R6-table", $sformatf("vec %0d ra", k), 64'(lk_ra), 64'(VECS[k].ra));
      check("R10-table", $sformatf("vec %0d miss_i", k), 64'(lk_miss_i), 64'(VECS[k].mi));
      check("R10-table", $sformatf("vec %0d miss_d", k), 64'(lk_miss_d), 64'(VECS[k].md));
      check("R4-table", $sformatf("vec %0d attr", k),
            64'({lk_ex, lk_wr, lk_zone, lk_wimg, lk_endian, lk_u0}), 64'(VECS[k].attr));
    end

    // R2: readback of both words, one cycle after the index
    @(negedge clk);
    sw_idx = 6'd10; sw_hi = 1'b1;
    @(negedge clk);
    check("R2", "hi readback", 64'(sw_rdata),
          64'(mk_hi(22'h2403FF, 3'd5, 1'b1, 1'b1, 1'b1, 8'd9)));
    sw_hi = 1'b0;
    @(negedge clk);
    check("R2", "lo readback", 64'(sw_rdata),
          64'(mk_lo(22'h2803FF, 1'b1, 1'b0, 4'hA, 4'h5)));

    // R12: write visible from its edge, not before
    @(negedge clk);
    look(32'hB000_0010, 1'b0, 1'b1, 8'd0);
    sw_wr = 1'b1; sw_hi = 1'b0; sw_idx = 6'd20;
    sw_wdata = mk_lo(22'h00C000, 1'b0, 1'b0, 4'h0, 4'h0);
    @(negedge clk);
    sw_hi = 1'b1; sw_wdata = mk_hi(22'h2C0000, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0);
    #1;
    check("R12", "hit before write edge", 64'(lk_hit), 64'h0);
    @(negedge clk);
    sw_wr = 1'b0;
    #1;
    check("R12", "hit after write edge", 64'(lk_hit), 64'h1);
    check("R12", "ra after write edge", 64'(lk_ra), 64'h0300_0010);
    check("R12", "idx after write edge", 64'(lk_idx), 64'd20);

    // R7: invalidating entry 9 removes its 64 KB page
    wr_word(6'd9, 1'b1, mk_hi(22'h140000, 3'd3, 1'b0, 1'b0, 1'b0, 8'd0));
    look(32'h5000_1ABC, 1'b1, 1'b1, 8'd0);
    check("R7", "hit on cleared valid", 64'(lk_hit), 64'h0);
    check("R7", "fetch miss on cleared valid", 64'(lk_miss_i), 64'h1);

    // R8: tagged entry with process ID zero does not match
    look(32'h3000_0123, 1'b0, 1'b1, 8'd0);
    check("R8", "tagged entry with pid 0", 64'(lk_hit), 64'h0);

    // R1: reset again clears the programmed table
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    look(32'h2012_3456, 1'b0, 1'b1, 8'd0);
    check("R1", "hit after second reset", 64'(lk_hit), 64'h0);
    check("R1", "rdata after second reset", 64'(sw_rdata), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule